// File: doc/BRIEF.md
# Strapped Identity Capture and Address Lock

This block gives a device its 14-bit identity when it comes out of reset. While the chip-wide active-low reset is held, the block keeps the output enables of two shared 8-bit pin buses switched off. External pull resistors then set the levels on those pins. The first clock edge that sees reset released takes a copy of the strapped levels. Six bits come from the sub-address bus and eight from the data bus.

If the memory-enable input is high at that edge, the block waits for a word from a simple boot-memory load port. That word replaces the strapped identity.

The upper six identity bits form the serial-bus device address. That address is locked once initialisation ends. Initialisation ends at reset release when there is no memory, or at the accepted load word when there is one. After that point the identity register can still be written, but the locked address does not change. The done flag also opens the bus output enables to the core's own requests.

Top module: `strap_id_capture`

## Requirements
- R1: On every clock edge that samples `rst_n` low, the block clears `ident` and `dev_addr` to 0 and drops `init_done`. Both bus output enables are low during the following cycle.
- R2: On the first edge that samples `rst_n` high after reset, `ident[13:8]` takes `sub_in[5:0]` and `ident[7:0]` takes `dat_in[7:0]`. Bits `sub_in[7:6]`, and any pin change after that edge, have no effect on `ident`.
- R3: If `mem_en` is low at that release edge, `init_done` is high from the next cycle on. `dev_addr` then equals the strapped `sub_in[5:0]`.
- R4: If `mem_en` is high at the release edge, `init_done` stays low and `ident` holds the strapped value until an edge samples `ld_valid` high. After that edge, `ident` equals `ld_word` and `dev_addr` equals `ld_word[13:8]`. `init_done` rises in the same cycle.
- R5: An `ld_valid` that is sampled in reset, on the release edge, or after `init_done` is high has no effect on `ident`, `dev_addr` or `init_done`.
- R6: While `init_done` is high, an edge that samples `wr_en` high loads `wr_word` into `ident`. `dev_addr` keeps its locked value.
- R7: A `wr_en` that is sampled while `init_done` is low has no effect.
- R8: `sub_oe` equals `sub_oe_req` and `dat_oe` equals `dat_oe_req` while `init_done` is high. Otherwise both are low.
- R9: `mem_en` is sampled only on the release edge. Changing it at any other time alters nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Chip-wide active-low reset, synchronous to clk |
| mem_en | input | 1 | Boot memory present; sampled at reset release |
| sub_in | input | 8 | Sub-address pin levels as seen from the pads |
| dat_in | input | 8 | Data pin levels as seen from the pads |
| sub_oe_req | input | 1 | Core's request to drive the sub-address bus |
| dat_oe_req | input | 1 | Core's request to drive the data bus |
| ld_valid | input | 1 | Boot-memory identity word valid strobe |
| ld_word | input | 14 | Identity word from boot memory |
| wr_en | input | 1 | Identity register write strobe |
| wr_word | input | 14 | Identity value to write |
| ident | output | 14 | Current device identity |
| dev_addr | output | 6 | Locked upper six bits of the serial-bus device address |
| init_done | output | 1 | Initialisation complete; register defaults valid |
| sub_oe | output | 1 | Sub-address bus output enable |
| dat_oe | output | 1 | Data bus output enable |

## Verification
The embedded properties assume the following about the inputs. `rst_n` is synchronous to `clk`. All inputs hold known values at every edge. A load strobe and a write strobe are judged only by the state the block is in when they arrive. The bench drives every input half a period after the rising edge, so each one is settled well before it is sampled. It keeps every input at a defined level, including the strobes during reset and on the release edge. It then deliberately places load and write strobes in reset, on the release edge, in the load window and after completion. This is how the precedence rules are exercised.

// File: rtl/sid_pkg.sv
package sid_pkg;
    localparam int ID_W   = 14;
    localparam int BUS_W  = 8;
    localparam int ADR_W  = 6;
    localparam int HI_W   = ID_W - BUS_W;
    localparam int N_BUS  = 2;

    typedef logic [ID_W-1:0]  id_t;
    typedef logic [ADR_W-1:0] adr_t;
    typedef logic [BUS_W-1:0] bus_t;

    typedef enum logic [1:0] {
        ST_HELD = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } init_st_e;

    typedef struct packed {
        logic vld;
        id_t  word;
    } id_upd_t;

    function automatic id_t straps_to_id(input bus_t sa, input bus_t da);
        return {sa[HI_W-1:0], da};
    endfunction

    function automatic adr_t id_to_addr(input id_t v);
        return v[ID_W-1 -: ADR_W];
    endfunction
endpackage

// File: rtl/sid_init_fsm.sv
module sid_init_fsm
    import sid_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     mem_en,
    input  logic     ld_valid,
    output init_st_e state,
    output logic     capture,
    output logic     load_take,
    output logic     lock_now
);
    init_st_e state_q;

    assign capture   = rst_n && (state_q == ST_HELD);
    assign load_take = rst_n && (state_q == ST_WAIT) && ld_valid;
    assign lock_now  = (capture && !mem_en) || load_take;
    assign state     = state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HELD;
        end else begin
            unique case (state_q)
                ST_HELD: state_q <= mem_en ? ST_WAIT : ST_DONE;
                ST_WAIT: if (ld_valid) state_q <= ST_DONE;
                ST_DONE: state_q <= ST_DONE;
                default: state_q <= ST_HELD;
            endcase
        end
    end

    assert_nomem_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && !mem_en) |=> (state_q == ST_DONE));

    assert_mem_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && mem_en) |=> (state_q == ST_WAIT));
endmodule

// File: rtl/sid_id_reg.sv
module sid_id_reg
    import sid_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    done,
    input  id_upd_t strap_upd,
    input  id_upd_t load_upd,
    input  id_upd_t write_upd,
    output id_t     id_q
);
    id_t id_r;
    id_t id_nxt;

    always_comb begin
        id_nxt = id_r;
        if (strap_upd.vld)
            id_nxt = strap_upd.word;
        else if (load_upd.vld)
            id_nxt = load_upd.word;
        else if (write_upd.vld && done)
            id_nxt = write_upd.word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) id_r <= '0;
        else        id_r <= id_nxt;
    end

    assign id_q = id_r;

    assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && write_upd.vld) |=> (id_r == $past(write_upd.word)));

    assert_early_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && write_upd.vld && !strap_upd.vld && !load_upd.vld) |=> $stable(id_r));
endmodule

// File: rtl/sid_addr_lock.sv
module sid_addr_lock
    import sid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_now,
    input  id_t  lock_src,
    output adr_t addr_q,
    output logic locked
);
    adr_t addr_r;
    logic locked_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_r   <= '0;
            locked_r <= 1'b0;
        end else if (lock_now && !locked_r) begin
            addr_r   <= id_to_addr(lock_src);
            locked_r <= 1'b1;
        end
    end

    assign addr_q = addr_r;
    assign locked = locked_r;

    assert_addr_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        locked_r |=> $stable(addr_r));
endmodule

// File: rtl/sid_pad_gate.sv
module sid_pad_gate
    import sid_pkg::*;
#(
    parameter int NB = N_BUS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          open,
    input  logic [NB-1:0] oe_req,
    output logic [NB-1:0] oe_out
);
    for (genvar b = 0; b < NB; b++) begin : g_bus
        assign oe_out[b] = oe_req[b] & open;
    end

    assert_oe_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !open |-> (oe_out == '0));
endmodule

// File: rtl/strap_id_capture.sv
module strap_id_capture
    import sid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mem_en,
    input  logic [BUS_W-1:0] sub_in,
    input  logic [BUS_W-1:0] dat_in,
    input  logic             sub_oe_req,
    input  logic             dat_oe_req,
    input  logic             ld_valid,
    input  logic [ID_W-1:0]  ld_word,
    input  logic             wr_en,
    input  logic [ID_W-1:0]  wr_word,
    output logic [ID_W-1:0]  ident,
    output logic [ADR_W-1:0] dev_addr,
    output logic             init_done,
    output logic             sub_oe,
    output logic             dat_oe
);
    init_st_e   st;
    logic       capture;
    logic       load_take;
    logic       lock_now;
    logic       locked;
    id_t        strap_id;
    id_upd_t    strap_upd;
    id_upd_t    load_upd;
    id_upd_t    write_upd;
    logic [N_BUS-1:0] oe_req;
    logic [N_BUS-1:0] oe_out;

    assign strap_id  = straps_to_id(sub_in, dat_in);
    assign strap_upd = '{vld: capture,   word: strap_id};
    assign load_upd  = '{vld: load_take, word: ld_word};
    assign write_upd = '{vld: wr_en,     word: wr_word};

    sid_init_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_en    (mem_en),
        .ld_valid  (ld_valid),
        .state     (st),
        .capture   (capture),
        .load_take (load_take),
        .lock_now  (lock_now)
    );

    assign init_done = (st == ST_DONE);

    sid_id_reg u_id (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (init_done),
        .strap_upd (strap_upd),
        .load_upd  (load_upd),
        .write_upd (write_upd),
        .id_q      (ident)
    );

    sid_addr_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_now (lock_now),
        .lock_src (capture ? strap_id : ld_word),
        .addr_q   (dev_addr),
        .locked   (locked)
    );

    assign oe_req = {dat_oe_req, sub_oe_req};

    sid_pad_gate #(.NB(N_BUS)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .open   (init_done),
        .oe_req (oe_req),
        .oe_out (oe_out)
    );

    assign sub_oe = oe_out[0];
    assign dat_oe = oe_out[1];

    assert_late_load_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && ld_valid && !wr_en) |=> ($stable(ident) && $stable(dev_addr)));

    assert_load_applies_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && ld_valid) |=>
            (init_done && ident == $past(ld_word) && dev_addr == $past(ld_word[ID_W-1 -: ADR_W])));

    assert_lock_matches_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        locked == init_done);
endmodule

// File: tb/strap_id_capture_tb_top.sv
module strap_id_capture_tb_top;
    logic        clk = 1'b0;
    logic        rst_n, mem_en, sub_oe_req, dat_oe_req, ld_valid, wr_en;
    logic [7:0]  sub_in, dat_in;
    logic [13:0] ld_word, wr_word;
    logic [13:0] ident;
    logic [5:0]  dev_addr;
    logic        init_done, sub_oe, dat_oe;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    running = 1'b0;
    string cur_req = "R1";

    int          m_st = 0;
    logic [13:0] m_id = '0;
    logic [5:0]  m_ad = '0;

    always #10 clk = ~clk;

    strap_id_capture dut_i (
        .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .sub_in(sub_in), .dat_in(dat_in),
        .sub_oe_req(sub_oe_req), .dat_oe_req(dat_oe_req), .ld_valid(ld_valid),
        .ld_word(ld_word), .wr_en(wr_en), .wr_word(wr_word), .ident(ident),
        .dev_addr(dev_addr), .init_done(init_done), .sub_oe(sub_oe), .dat_oe(dat_oe)
    );

    // Behavioural reference: 0 = held in reset, 1 = waiting for memory word, 2 = done
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_id = '0; m_ad = '0;
        end else if (m_st == 0) begin
            m_id = {sub_in[5:0], dat_in};
            if (mem_en) m_st = 1;
            else begin m_st = 2; m_ad = sub_in[5:0]; end
        end else if (m_st == 1) begin
            if (ld_valid) begin m_id = ld_word; m_ad = ld_word[13:8]; m_st = 2; end
        end else if (wr_en) begin
            m_id = wr_word;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always begin
        @(posedge clk);
        #15;
        if (running) begin
            chk("ident",     {18'd0, ident},    {18'd0, m_id});
            chk("dev_addr",  {26'd0, dev_addr}, {26'd0, m_ad});
            chk("init_done", {31'd0, init_done}, {31'd0, (m_st == 2)});
            chk("sub_oe",    {31'd0, sub_oe},   {31'd0, (sub_oe_req && m_st == 2)});
            chk("dat_oe",    {31'd0, dat_oe},   {31'd0, (dat_oe_req && m_st == 2)});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_bad++;
            $display("FAIL watchdog expired actual %0d expected below 5000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; mem_en = 1'b0; sub_in = 8'hC5; dat_in = 8'h3C;
        sub_oe_req = 1'b1; dat_oe_req = 1'b1; ld_valid = 1'b1; ld_word = 14'h1111;
        wr_en = 1'b1; wr_word = 14'h2222;
        @(negedge clk);
        running = 1'b1;
        // R1: reset clears outputs, enables held off despite requests and strobes
        cur_req = "R1"; idle(4);
        ld_valid = 1'b0; wr_en = 1'b0;
        // R2/R3: release with no memory; upper strap bits 7:6 set but ignored
        cur_req = "R2"; rst_n = 1'b1; idle(1);
        cur_req = "R3"; idle(2);
        cur_req = "R2"; sub_in = 8'h00; dat_in = 8'hFF; idle(2);
        // R5: load after completion ignored
        cur_req = "R5"; ld_valid = 1'b1; ld_word = 14'h1234; idle(2); ld_valid = 1'b0;
        // R6: writes after completion land, address stays
        cur_req = "R6"; wr_en = 1'b1; wr_word = 14'h3FFF; idle(1);
        wr_word = 14'h0001; idle(1); wr_en = 1'b0; idle(1);
        // R8: enable pass-through patterns
        cur_req = "R8";
        sub_oe_req = 1'b0; dat_oe_req = 1'b1; idle(1);
        sub_oe_req = 1'b1; dat_oe_req = 1'b0; idle(1);
        sub_oe_req = 1'b0; dat_oe_req = 1'b0; idle(1);
        sub_oe_req = 1'b1; dat_oe_req = 1'b1; idle(1);
        // R9: memory enable changes after release have no effect
        cur_req = "R9"; mem_en = 1'b1; idle(2); mem_en = 1'b0;
        // Second reset, memory present
        cur_req = "R1"; rst_n = 1'b0; mem_en = 1'b1; sub_in = 8'h3F; dat_in = 8'hA5; idle(3);
        // R5: strobe on the release edge is ignored
        cur_req = "R5"; rst_n = 1'b1; ld_valid = 1'b1; ld_word = 14'h0ABC; idle(1);
        ld_valid = 1'b0;
        // R7: writes during the load window are dropped
        cur_req = "R7"; wr_en = 1'b1; wr_word = 14'h1555; idle(2); wr_en = 1'b0;
        // R9: memory enable dropped during the wait; still waiting
        cur_req = "R9"; mem_en = 1'b0; sub_in = 8'h12; idle(2);
        // R4: memory word replaces straps
        cur_req = "R4"; ld_valid = 1'b1; ld_word = 14'h2B7E; idle(1);
        ld_valid = 1'b0; idle(2);
        cur_req = "R6"; wr_en = 1'b1; wr_word = 14'h0F0F; idle(1); wr_en = 1'b0; idle(1);
        // R1: reset in the middle of a load window
        cur_req = "R1"; rst_n = 1'b0; mem_en = 1'b1; sub_in = 8'h2D; dat_in = 8'h5A; idle(2);
        cur_req = "R4"; rst_n = 1'b1; idle(2);
        cur_req = "R1"; rst_n = 1'b0; mem_en = 1'b0; sub_in = 8'h00; dat_in = 8'h00; idle(2);
        cur_req = "R3"; rst_n = 1'b1; idle(3);
        running = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule